// File: doc/BRIEF.md
# Floating-Point Status Update and Exception Accrual

This block holds the 32-bit floating-point status word and rewrites it each time an arithmetic unit reports a result. The arithmetic unit supplies three things with a one-cycle strobe: the class of the result, its sign, and the exception flags raised by that operation. The block then does four things:

- It rebuilds the condition-code nibble.
- It replaces the current-exception byte.
- It merges that byte into the sticky accrued-exception bits, using the accrual rules below.
- It raises a one-cycle trap request when any current exception is also enabled in the control enable byte.

A host write port loads the whole status word and takes priority over an update in the same cycle. This port is the only way, apart from reset, to clear the accrued bits.

Top module: `fpstat_accrue`

## Requirements
- R1: During and after a synchronous reset (`rst` high), `status` reads 0 and `trap_req` is low.
- R2: On an update, the condition nibble (bit 27 negative, bit 26 zero, bit 25 infinity, bit 24 NaN) is first cleared. Bit 27 then takes `res_sign`. `res_class` selects one class bit: 0 finite (none), 1 zero (bit 26), 2 infinity (bit 25), 3 quiet NaN (bit 24), 4 signalling NaN (bit 24). Codes 5 to 7 act as finite.
- R3: A signalling-NaN result sets both bit 24 and the signalling-NaN exception bit 14. A quiet-NaN result sets bit 24 only.
- R4: On an update, bits 15:8 are replaced by `op_exc` (plus bit 14 from R3). From high to low the bits are branch-unordered, signalling NaN, operand error, overflow, underflow, divide-by-zero, inexact result and inexact operation.
- R5: Accrued invalid (bit 7) is set when the new branch-unordered, signalling-NaN or operand-error bit is set.
- R6: Accrued underflow (bit 5) is set only when the new underflow and inexact-result bits are both set.
- R7: Accrued inexact (bit 3) is set by inexact operation, inexact result or overflow. Accrued overflow (bit 6) follows overflow, and accrued divide-by-zero (bit 4) follows divide-by-zero.
- R8: An update never clears an accrued bit (bits 7:3).
- R9: `trap_req` is registered. It is high for the one cycle after an update strobe whose new exception byte ANDed with `enable_mask` is nonzero, and low otherwise.
- R10: When `wr_en` is high, `status` loads `wr_data` at the next edge. A simultaneous update is dropped and raises no trap.
- R11: Without `wr_en` or `upd_valid`, `status` holds. An update leaves bits 31:28, 23:16 and 2:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the status word |
| wr_data | input | 32 | Value loaded by a host write |
| upd_valid | input | 1 | One-cycle strobe for a new arithmetic result |
| res_class | input | 3 | Result class code (see R2) |
| res_sign | input | 1 | Result sign |
| op_exc | input | 8 | Exception flags of this operation |
| enable_mask | input | 8 | Exception enable byte from the control register |
| status | output | 32 | Current status word |
| trap_req | output | 1 | Registered trap request |

## Verification
The bench builds the block with its default field positions: condition nibble at bit 24, exception byte at bit 8 and accrued bits at bit 3. These defaults put every field at the bit numbers named in the requirements, so the table vectors can be checked field by field against a status model written in the bench. Each vector is applied over a preloaded word with ones in the unused bits, which brings the preservation rule within reach. The directed cases cover three behaviours: accrued bits persisting across a clean update, a write colliding with an update, and idle hold.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

    localparam int CC_W  = 4;
    localparam int EXC_W = 8;
    localparam int ACC_W = 5;

    typedef enum logic [2:0] {
        CLS_NUM  = 3'd0,
        CLS_ZERO = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } res_class_e;

    // Condition nibble, high to low
    typedef struct packed {
        logic neg;
        logic zero;
        logic inf;
        logic nan;
    } cc_t;

    // Current-exception byte, high to low
    typedef struct packed {
        logic bsun;
        logic snan;
        logic operr;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex2;
        logic inex1;
    } exc_t;

    // Accrued field, high to low
    typedef struct packed {
        logic iop;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex;
    } acc_t;

    // Accrual contribution of one exception byte
    function automatic acc_t acc_contrib(exc_t e);
        acc_t a;
        a.iop  = e.bsun | e.snan | e.operr;
        a.ovfl = e.ovfl;
        a.unfl = e.unfl & e.inex2;
        a.dz   = e.dz;
        a.inex = e.inex1 | e.inex2 | e.ovfl;
        return a;
    endfunction

endpackage

// File: rtl/fpstat_cc_gen.sv
module fpstat_cc_gen
    import fpstat_pkg::*;
(
    input  logic [2:0] cls,
    input  logic       sign,
    output cc_t        cc,
    output logic       snan_hit
);
    always_comb begin
        cc       = '0;
        cc.neg   = sign;
        snan_hit = 1'b0;
        case (res_class_e'(cls))
            CLS_ZERO: cc.zero = 1'b1;
            CLS_INF:  cc.inf  = 1'b1;
            CLS_QNAN: cc.nan  = 1'b1;
            CLS_SNAN: begin
                cc.nan   = 1'b1;
                snan_hit = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/fpstat_acc_merge.sv
module fpstat_acc_merge
    import fpstat_pkg::*;
(
    input  acc_t acc_old,
    input  exc_t exc_new,
    output acc_t acc_next
);
    acc_t contrib;
    always_comb begin
        contrib  = acc_contrib(exc_new);
        acc_next = acc_old | contrib;
    end
endmodule

// File: rtl/fpstat_trap_detect.sv
module fpstat_trap_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] exc,
    input  logic [WIDTH-1:0] en,
    output logic             hit
);
    logic [WIDTH-1:0] masked;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign masked[i] = exc[i] & en[i];
    end
    assign hit = |masked;
endmodule

// File: rtl/fpstat_accrue.sv
module fpstat_accrue
    import fpstat_pkg::*;
#(
    parameter int STAT_W  = 32,
    parameter int CC_LSB  = 24,
    parameter int EXC_LSB = 8,
    parameter int ACC_LSB = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              upd_valid,
    input  logic [2:0]        res_class,
    input  logic              res_sign,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic [EXC_W-1:0]  enable_mask,
    output logic [STAT_W-1:0] status,
    output logic              trap_req
);
    localparam int CC_MSB    = CC_LSB + CC_W - 1;
    localparam int EXC_MSB   = EXC_LSB + EXC_W - 1;
    localparam int ACC_MSB   = ACC_LSB + ACC_W - 1;
    localparam int ACC_UNFL  = ACC_LSB + 2;
    localparam int EXC_UNFL  = EXC_LSB + 3;
    localparam int EXC_INEX2 = EXC_LSB + 1;

    logic [STAT_W-1:0] status_q, status_d;
    logic              trap_q;
    logic              past_ok;
    cc_t               cc_new;
    logic              snan_hit;
    exc_t              exc_new;
    acc_t              acc_old, acc_new;
    logic              trap_hit;
    logic              do_upd;

    fpstat_cc_gen u_cc (
        .cls      (res_class),
        .sign     (res_sign),
        .cc       (cc_new),
        .snan_hit (snan_hit)
    );

    always_comb begin
        exc_new      = exc_t'(op_exc);
        exc_new.snan = exc_new.snan | snan_hit;
    end

    assign acc_old = acc_t'(status_q[ACC_MSB:ACC_LSB]);

    fpstat_acc_merge u_acc (
        .acc_old  (acc_old),
        .exc_new  (exc_new),
        .acc_next (acc_new)
    );

    fpstat_trap_detect #(.WIDTH(EXC_W)) u_trap (
        .exc (exc_new),
        .en  (enable_mask),
        .hit (trap_hit)
    );

    assign do_upd = upd_valid & ~wr_en;

    always_comb begin
        status_d = status_q;
        if (wr_en) begin
            status_d = wr_data;
        end else if (upd_valid) begin
            status_d[CC_MSB:CC_LSB]   = cc_new;
            status_d[EXC_MSB:EXC_LSB] = exc_new;
            status_d[ACC_MSB:ACC_LSB] = acc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            trap_q   <= 1'b0;
            past_ok  <= 1'b0;
        end else begin
            status_q <= status_d;
            trap_q   <= do_upd & trap_hit;
            past_ok  <= 1'b1;
        end
    end

    assign status   = status_q;
    assign trap_req = trap_q;

    // R9: trap only in the cycle after an accepted update
    assert_trap_after_strobe_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
        trap_q |-> $past(upd_valid && !wr_en));

    // R9: a trap implies an enabled bit in the stored exception byte
    assert_trap_enabled_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
        trap_q |-> ((status_q[EXC_MSB:EXC_LSB] & $past(enable_mask)) != '0));

    // R10: host write wins
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(wr_en) |-> (status_q == $past(wr_data)));

    // R8: accrued bits never drop without a write
    assert_accrued_sticky_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(wr_en) |-> ((status_q[ACC_MSB:ACC_LSB] & $past(status_q[ACC_MSB:ACC_LSB]))
                           == $past(status_q[ACC_MSB:ACC_LSB])));

    // R2: at most one class bit after an update
    assert_one_class_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(upd_valid && !wr_en) |-> $onehot0(status_q[CC_LSB+2:CC_LSB]));

    // R11: idle cycles hold the word
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(!wr_en && !upd_valid) |-> $stable(status_q));

    // R6: a new accrued underflow needs both underflow and inexact result
    assert_unfl_pair_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(upd_valid && !wr_en) && !$past(status_q[ACC_UNFL]) && status_q[ACC_UNFL])
        |-> (status_q[EXC_UNFL] && status_q[EXC_INEX2]));

endmodule

// File: tb/test_fpstat_accrue.sv
module test_fpstat_accrue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        upd_valid = 1'b0;
    logic [2:0]  res_class = '0;
    logic        res_sign = 1'b0;
    logic [7:0]  op_exc = '0;
    logic [7:0]  enable_mask = '0;
    logic [31:0] status;
    logic        trap_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpstat_accrue i_fpstat_accrue (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .upd_valid(upd_valid), .res_class(res_class), .res_sign(res_sign),
        .op_exc(op_exc), .enable_mask(enable_mask),
        .status(status), .trap_req(trap_req)
    );

    // {class[27:24], sign[23:20], exc[19:12], enable[11:4], trap[3:0]}
    localparam logic [27:0] VEC [11] = '{
        28'h0000FF0, 28'h1100000, 28'h2010101, 28'h3120000,
        28'h4000401, 28'h0108020, 28'h000A081, 28'h0001020,
        28'h1004041, 28'h00807F0, 28'h5100000
    };
    localparam logic [31:0] PRESET = 32'hA05A_0002;

    // Expected status from the requirement text
    function automatic logic [31:0] model(logic [31:0] old, logic [2:0] cls,
                                          logic sgn, logic [7:0] exc);
        logic [31:0] s;
        logic [7:0]  e;
        s = old;
        e = exc;
        s[27:24] = 4'b0000;
        s[27] = sgn;
        if (cls == 3'd1) s[26] = 1'b1;
        if (cls == 3'd2) s[25] = 1'b1;
        if (cls == 3'd3) s[24] = 1'b1;
        if (cls == 3'd4) begin s[24] = 1'b1; e[6] = 1'b1; end
        s[15:8] = e;
        if (e[7] || e[6] || e[5]) s[7] = 1'b1;
        if (e[4]) s[6] = 1'b1;
        if (e[3] && e[1]) s[5] = 1'b1;
        if (e[2]) s[4] = 1'b1;
        if (e[1] || e[0] || e[4]) s[3] = 1'b1;
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic update(logic [2:0] c, logic s, logic [7:0] e, logic [7:0] en);
        @(negedge clk);
        res_class = c; res_sign = s; op_exc = e; enable_mask = en;
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] exp_s;
        repeat (3) @(negedge clk);
        check("R1 status in reset", status, 32'h0);
        check("R1 trap in reset", {31'b0, trap_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status after reset", status, 32'h0);

        // Table walk
        for (int i = 0; i < 11; i++) begin
            host_write(PRESET);
            exp_s = model(PRESET, VEC[i][26:24], VEC[i][20], VEC[i][19:12]);
            update(VEC[i][26:24], VEC[i][20], VEC[i][19:12], VEC[i][11:4]);
            check("R2/R3 cond nibble", {28'b0, status[27:24]}, {28'b0, exp_s[27:24]});
            check("R3/R4 exception byte", {24'b0, status[15:8]}, {24'b0, exp_s[15:8]});
            check("R5/R6/R7 accrued", {27'b0, status[7:3]}, {27'b0, exp_s[7:3]});
            check("R11 other bits", status & 32'hF0FF_0007, PRESET & 32'hF0FF_0007);
            check("R9 trap", {31'b0, trap_req}, {31'b0, VEC[i][0]});
            @(negedge clk);
            check("R9 trap one cycle", {31'b0, trap_req}, 32'h0);
        end

        // R6 underflow alone does not accrue
        host_write(32'h0);
        update(3'd0, 1'b0, 8'h08, 8'h00);
        check("R6 lone underflow", {31'b0, status[5]}, 32'h0);

        // R8 stickiness across a clean update
        host_write(32'h0);
        update(3'd0, 1'b0, 8'h10, 8'h00);
        check("R7 overflow accrues ovfl+inex", {24'b0, status[7:0]}, 32'h48);
        update(3'd1, 1'b0, 8'h00, 8'h00);
        check("R8 accrued kept", {24'b0, status[7:0]}, 32'h48);
        check("R8 exc byte replaced", {24'b0, status[15:8]}, 32'h0);

        // R10 write collides with update
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h1234_5678;
        upd_valid = 1'b1; res_class = 3'd4; op_exc = 8'hFF; enable_mask = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0; upd_valid = 1'b0;
        check("R10 write value", status, 32'h1234_5678);
        check("R10 no trap", {31'b0, trap_req}, 32'h0);

        // R11 idle hold
        repeat (4) @(negedge clk);
        check("R11 idle hold", status, 32'h1234_5678);

        // R1 reset clears a loaded word
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears", status, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule